// File: doc/BRIEF.md
# Bucket-Partitioned Receive Message Queue

This block is the receive side of one station on an on-chip message ring. A single shared message store of 256 entries is carved into up to eight independent circular queues, here called buckets. Software sets the size of each bucket, and each bucket's region starts where the previous one ends. Arriving messages carry a bucket number, the sender's station ID and a payload. Each one is appended to its bucket's queue unless that bucket is full.

A consumer names a bucket to dequeue. One cycle later the oldest message in that bucket appears at the read outputs. In the same cycle a credit-return pulse carries the bucket number and the original sender's ID, so that the sender can replenish its credit for that bucket. Per-bucket empty, full, occupancy and sticky overflow status are always visible. A configuration check flags bucket layouts that break the alignment rule or do not fit in the store.

Top module: `bucket_rx_queue`

## Requirements
- R1: Every bucket delivers its messages in arrival order. Traffic to one bucket never changes the contents or order of another bucket.
- R2: `cfg_err_o` is high exactly when one of these holds:
  - a nonzero bucket size is not a power of two;
  - a nonzero bucket's start (the sum of the sizes of the lower-numbered buckets) is not a multiple of its size;
  - the sizes add up to more than 256.
- R3: A dequeue of a non-empty bucket makes `rd_valid_o` high in the next cycle, with that bucket's oldest payload on `rd_data_o` and its sender on `rd_src_o`.
- R4: In the same cycle as R3's read, `crd_valid_o` pulses with `crd_bkt_o` equal to the dequeued bucket number and `crd_src_o` equal to the message's sender ID.
- R5: A dequeue of an empty bucket is ignored. No read or credit follows, and no status changes.
- R6: An enqueue to a full bucket is dropped and leaves the bucket's contents unchanged. It sets that bucket's bit of `ovf_o`, which stays high until reset.
- R7: A bucket of size 0 always reports empty and full with a count of 0. Every enqueue to it is dropped and sets its overflow bit.
- R8: `count_o` slice b (9 bits at bit position 9*b) gives bucket b's occupancy and changes on the clock edge that accepts an operation. `empty_o[b]` is high when the count is 0, and `full_o[b]` is high when the count equals the bucket size.
- R9: An enqueue and a dequeue to the same bucket in one cycle both take effect, and the count is unchanged. Whether the enqueue is accepted depends only on the occupancy at the start of the cycle, so on a full bucket the dequeue proceeds and the enqueue is dropped.
- R10: Each bucket's queue wraps within its own region. A bucket that has been filled to capacity, drained and refilled keeps arrival order.
- R11: After synchronous reset every bucket is empty with count 0, no overflow bit is set, and `rd_valid_o` and `crd_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_size_i | input | 72 | Bucket sizes, 9 bits per bucket, bucket b at bit 9*b; hold stable outside reset |
| cfg_err_o | output | 1 | Bucket layout violates the alignment or capacity rule |
| enq_valid_i | input | 1 | Enqueue request |
| enq_bkt_i | input | 3 | Target bucket of the enqueue |
| enq_src_i | input | 4 | Sender station ID |
| enq_data_i | input | 32 | Message payload |
| deq_valid_i | input | 1 | Dequeue request |
| deq_bkt_i | input | 3 | Bucket to dequeue from |
| rd_valid_o | output | 1 | Read result valid (one cycle after an accepted dequeue) |
| rd_data_o | output | 32 | Dequeued payload |
| rd_src_o | output | 4 | Sender ID of the dequeued message |
| crd_valid_o | output | 1 | Credit-return pulse |
| crd_bkt_o | output | 3 | Bucket the credit belongs to |
| crd_src_o | output | 4 | Station that receives the credit |
| empty_o | output | 8 | Per-bucket empty |
| full_o | output | 8 | Per-bucket full |
| ovf_o | output | 8 | Per-bucket sticky overflow |
| count_o | output | 72 | Per-bucket occupancy, 9 bits per bucket |

## Verification
The bench uses a layout that mixes small buckets and zero-sized buckets in between them. This makes wrap-around, full and empty occur often.

Each corner case targets a specific bug:
- Wrap test: a design that wraps pointers at the store size instead of the bucket size returns stale entries or overwrites a neighbour's region.
- Simultaneous enqueue and dequeue, both on a partly filled and on a full bucket: a design that judges fullness after the dequeue accepts a message it should have dropped. One that counts only one of the two operations drifts its count.
- Dequeues from empty and zero-sized buckets: a design that lets them through emits spurious reads and credits.
- Layouts with a misaligned start, a non-power-of-two size or too large a total: a design with a wrong alignment check misses the configuration error.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    parameter int unsigned STORE_DEPTH = 256;
    parameter int unsigned NUM_BKT     = 8;
    parameter int unsigned DATA_W      = 32;
    parameter int unsigned SRC_W       = 4;

    parameter int unsigned ADDR_W = $clog2(STORE_DEPTH);
    parameter int unsigned SZ_W   = ADDR_W + 1;
    parameter int unsigned BKT_W  = $clog2(NUM_BKT);
    parameter int unsigned SUM_W  = SZ_W + BKT_W;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [SZ_W-1:0]   size_t;
    typedef logic [BKT_W-1:0]  bkt_t;

    typedef struct packed {
        logic [SRC_W-1:0]  src;
        logic [DATA_W-1:0] data;
    } msg_t;

    // True for zero and for powers of two.
    function automatic logic pow2_or_zero(input size_t s);
        return (s & (s - size_t'(1))) == '0;
    endfunction

    // Advance an offset inside a region of s entries.
    function automatic addr_t wrap_inc(input addr_t p, input size_t s);
        if ({1'b0, p} == s - size_t'(1))
            return '0;
        return p + addr_t'(1);
    endfunction
endpackage

// File: rtl/rxq_cfg.sv
module rxq_cfg
    import rxq_pkg::*;
(
    input  size_t size_i [NUM_BKT],
    output addr_t base_o [NUM_BKT],
    output logic  err_o
);
    logic [SUM_W-1:0] run;
    logic             err;

    always_comb begin
        run = '0;
        err = 1'b0;
        for (int i = 0; i < NUM_BKT; i++) begin
            base_o[i] = addr_t'(run);
            if (size_i[i] != '0) begin
                if (!pow2_or_zero(size_i[i]))
                    err = 1'b1;
                if ((run & SUM_W'(size_i[i] - size_t'(1))) != '0)
                    err = 1'b1;
            end
            run = run + SUM_W'(size_i[i]);
        end
        if (run > SUM_W'(STORE_DEPTH))
            err = 1'b1;
        err_o = err;
    end
endmodule

// File: rtl/rxq_bucket_ctl.sv
module rxq_bucket_ctl
    import rxq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  size_t size_i,
    input  addr_t base_i,
    input  logic  enq_req_i,
    input  logic  deq_req_i,
    output logic  enq_ok_o,
    output logic  deq_ok_o,
    output addr_t wr_addr_o,
    output addr_t rd_addr_o,
    output size_t count_o,
    output logic  empty_o,
    output logic  full_o,
    output logic  ovf_o
);
    addr_t head_q, tail_q;
    size_t cnt_q;
    logic  ovf_q;

    assign full_o   = (cnt_q == size_i);
    assign empty_o  = (cnt_q == '0);
    assign enq_ok_o = enq_req_i && !full_o;
    assign deq_ok_o = deq_req_i && !empty_o;

    assign wr_addr_o = base_i + tail_q;
    assign rd_addr_o = base_i + head_q;
    assign count_o   = cnt_q;
    assign ovf_o     = ovf_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
            ovf_q  <= 1'b0;
        end else begin
            if (enq_ok_o)
                tail_q <= wrap_inc(tail_q, size_i);
            if (deq_ok_o)
                head_q <= wrap_inc(head_q, size_i);
            case ({enq_ok_o, deq_ok_o})
                2'b10:   cnt_q <= cnt_q + size_t'(1);
                2'b01:   cnt_q <= cnt_q - size_t'(1);
                default: cnt_q <= cnt_q;
            endcase
            if (enq_req_i && full_o)
                ovf_q <= 1'b1;
        end
    end
endmodule

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
(
    input  logic  clk,
    input  logic  we_i,
    input  addr_t waddr_i,
    input  msg_t  wdata_i,
    input  logic  re_i,
    input  addr_t raddr_i,
    output msg_t  rdata_o
);
    msg_t mem [STORE_DEPTH];
    msg_t rdata_q;

    always_ff @(posedge clk) begin
        if (we_i)
            mem[waddr_i] <= wdata_i;
        if (re_i)
            rdata_q <= mem[raddr_i];
    end

    assign rdata_o = rdata_q;
endmodule

// File: rtl/bucket_rx_queue.sv
module bucket_rx_queue
    import rxq_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM_BKT*SZ_W-1:0]   cfg_size_i,
    output logic                      cfg_err_o,
    input  logic                      enq_valid_i,
    input  logic [BKT_W-1:0]          enq_bkt_i,
    input  logic [SRC_W-1:0]          enq_src_i,
    input  logic [DATA_W-1:0]         enq_data_i,
    input  logic                      deq_valid_i,
    input  logic [BKT_W-1:0]          deq_bkt_i,
    output logic                      rd_valid_o,
    output logic [DATA_W-1:0]         rd_data_o,
    output logic [SRC_W-1:0]          rd_src_o,
    output logic                      crd_valid_o,
    output logic [BKT_W-1:0]          crd_bkt_o,
    output logic [SRC_W-1:0]          crd_src_o,
    output logic [NUM_BKT-1:0]        empty_o,
    output logic [NUM_BKT-1:0]        full_o,
    output logic [NUM_BKT-1:0]        ovf_o,
    output logic [NUM_BKT*SZ_W-1:0]   count_o
);
    size_t size_v  [NUM_BKT];
    addr_t base_v  [NUM_BKT];
    addr_t wr_addr [NUM_BKT];
    addr_t rd_addr [NUM_BKT];
    size_t cnt_v   [NUM_BKT];
    logic [NUM_BKT-1:0] enq_req, deq_req, enq_ok, deq_ok;

    for (genvar g = 0; g < NUM_BKT; g++) begin : g_bkt
        assign size_v[g]  = cfg_size_i[g*SZ_W +: SZ_W];
        assign enq_req[g] = enq_valid_i && (enq_bkt_i == bkt_t'(g));
        assign deq_req[g] = deq_valid_i && (deq_bkt_i == bkt_t'(g));
        assign count_o[g*SZ_W +: SZ_W] = cnt_v[g];

        rxq_bucket_ctl u_ctl (
            .clk       (clk),
            .rst       (rst),
            .size_i    (size_v[g]),
            .base_i    (base_v[g]),
            .enq_req_i (enq_req[g]),
            .deq_req_i (deq_req[g]),
            .enq_ok_o  (enq_ok[g]),
            .deq_ok_o  (deq_ok[g]),
            .wr_addr_o (wr_addr[g]),
            .rd_addr_o (rd_addr[g]),
            .count_o   (cnt_v[g]),
            .empty_o   (empty_o[g]),
            .full_o    (full_o[g]),
            .ovf_o     (ovf_o[g])
        );
    end

    rxq_cfg u_cfg (
        .size_i (size_v),
        .base_o (base_v),
        .err_o  (cfg_err_o)
    );

    msg_t wmsg, rmsg;
    logic we, re;
    assign wmsg.src  = enq_src_i;
    assign wmsg.data = enq_data_i;
    assign we = |enq_ok;
    assign re = |deq_ok;

    rxq_store u_store (
        .clk     (clk),
        .we_i    (we),
        .waddr_i (wr_addr[enq_bkt_i]),
        .wdata_i (wmsg),
        .re_i    (re),
        .raddr_i (rd_addr[deq_bkt_i]),
        .rdata_o (rmsg)
    );

    logic rd_vld_q;
    bkt_t rd_bkt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_vld_q <= 1'b0;
            rd_bkt_q <= '0;
        end else begin
            rd_vld_q <= re;
            if (re)
                rd_bkt_q <= deq_bkt_i;
        end
    end

    assign rd_valid_o  = rd_vld_q;
    assign rd_data_o   = rmsg.data;
    assign rd_src_o    = rmsg.src;
    assign crd_valid_o = rd_vld_q;
    assign crd_bkt_o   = rd_bkt_q;
    assign crd_src_o   = rmsg.src;
endmodule

// File: rtl/rxq_checker.sv
module rxq_checker
    import rxq_pkg::*;
(
    input logic                    clk,
    input logic                    rst,
    input logic [NUM_BKT*SZ_W-1:0] cfg_size_i,
    input logic                    enq_valid_i,
    input logic [BKT_W-1:0]        enq_bkt_i,
    input logic                    deq_valid_i,
    input logic [BKT_W-1:0]        deq_bkt_i,
    input logic                    rd_valid_o,
    input logic                    crd_valid_o,
    input logic [BKT_W-1:0]        crd_bkt_o,
    input logic [NUM_BKT-1:0]      empty_o,
    input logic [NUM_BKT-1:0]      full_o,
    input logic [NUM_BKT-1:0]      ovf_o,
    input logic [NUM_BKT*SZ_W-1:0] count_o
);
    AST_DEQ_READS: assert property (@(posedge clk) disable iff (rst)
        deq_valid_i && !empty_o[deq_bkt_i] |=> rd_valid_o); // R3

    AST_CREDIT_BKT: assert property (@(posedge clk) disable iff (rst)
        deq_valid_i && !empty_o[deq_bkt_i] |=> crd_valid_o && crd_bkt_o == $past(deq_bkt_i)); // R4

    AST_EMPTY_DEQ_IGNORED: assert property (@(posedge clk) disable iff (rst)
        deq_valid_i && empty_o[deq_bkt_i] |=> !rd_valid_o && !crd_valid_o); // R5

    AST_FULL_DROP_FLAGS: assert property (@(posedge clk) disable iff (rst)
        enq_valid_i && full_o[enq_bkt_i] |=> ovf_o[$past(enq_bkt_i)]); // R6

    for (genvar i = 0; i < NUM_BKT; i++) begin : g_chk
        logic [SZ_W-1:0] cnt_w, size_w;
        logic            enq_hit, deq_hit;
        assign cnt_w   = count_o[i*SZ_W +: SZ_W];
        assign size_w  = cfg_size_i[i*SZ_W +: SZ_W];
        assign enq_hit = enq_valid_i && enq_bkt_i == bkt_t'(i) && !full_o[i];
        assign deq_hit = deq_valid_i && deq_bkt_i == bkt_t'(i) && !empty_o[i];

        AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
            ovf_o[i] |=> ovf_o[i]); // R6

        AST_ZERO_SIZE: assert property (@(posedge clk) disable iff (rst)
            size_w == '0 |-> empty_o[i] && full_o[i]); // R7

        AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
            cnt_w <= size_w); // R8

        AST_BOTH_OPS_HOLD: assert property (@(posedge clk) disable iff (rst)
            enq_hit && deq_hit |=> $stable(cnt_w)); // R9
    end
endmodule

bind bucket_rx_queue rxq_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_size_i  (cfg_size_i),
    .enq_valid_i (enq_valid_i),
    .enq_bkt_i   (enq_bkt_i),
    .deq_valid_i (deq_valid_i),
    .deq_bkt_i   (deq_bkt_i),
    .rd_valid_o  (rd_valid_o),
    .crd_valid_o (crd_valid_o),
    .crd_bkt_o   (crd_bkt_o),
    .empty_o     (empty_o),
    .full_o      (full_o),
    .ovf_o       (ovf_o),
    .count_o     (count_o)
);

// File: tb/bucket_rx_queue_test.sv
`timescale 1ns/1ps
module bucket_rx_queue_test;
    import rxq_pkg::*;

    localparam int MW = SRC_W + DATA_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NUM_BKT*SZ_W-1:0] cfg_size_i;
    logic cfg_err_o;
    logic enq_valid_i = 1'b0;
    logic [BKT_W-1:0] enq_bkt_i = '0;
    logic [SRC_W-1:0] enq_src_i = '0;
    logic [DATA_W-1:0] enq_data_i = '0;
    logic deq_valid_i = 1'b0;
    logic [BKT_W-1:0] deq_bkt_i = '0;
    logic rd_valid_o, crd_valid_o;
    logic [DATA_W-1:0] rd_data_o;
    logic [SRC_W-1:0] rd_src_o, crd_src_o;
    logic [BKT_W-1:0] crd_bkt_o;
    logic [NUM_BKT-1:0] empty_o, full_o, ovf_o;
    logic [NUM_BKT*SZ_W-1:0] count_o;

    always #2.5 clk = ~clk;

    bucket_rx_queue uut (
        .clk(clk), .rst(rst), .cfg_size_i(cfg_size_i), .cfg_err_o(cfg_err_o),
        .enq_valid_i(enq_valid_i), .enq_bkt_i(enq_bkt_i), .enq_src_i(enq_src_i),
        .enq_data_i(enq_data_i), .deq_valid_i(deq_valid_i), .deq_bkt_i(deq_bkt_i),
        .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o), .rd_src_o(rd_src_o),
        .crd_valid_o(crd_valid_o), .crd_bkt_o(crd_bkt_o), .crd_src_o(crd_src_o),
        .empty_o(empty_o), .full_o(full_o), .ovf_o(ovf_o), .count_o(count_o)
    );

    int n_chk = 0;
    int n_err = 0;

    int sz [NUM_BKT];
    int hd [NUM_BKT];
    int ct [NUM_BKT];
    logic [MW-1:0] q [NUM_BKT][STORE_DEPTH];
    logic [NUM_BKT-1:0] m_ovf;
    int seq = 0;

    task automatic chk(input logic ok, input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [NUM_BKT*SZ_W-1:0] pack_cfg();
        logic [NUM_BKT*SZ_W-1:0] v = '0;
        for (int i = 0; i < NUM_BKT; i++) v[i*SZ_W +: SZ_W] = SZ_W'(sz[i]);
        return v;
    endfunction

    function automatic logic exp_cfg_err();
        int run = 0;
        logic e = 1'b0;
        for (int i = 0; i < NUM_BKT; i++) begin
            if (sz[i] != 0) begin
                if ((sz[i] & (sz[i] - 1)) != 0) e = 1'b1;
                if (run % sz[i] != 0) e = 1'b1;
            end
            run += sz[i];
        end
        if (run > STORE_DEPTH) e = 1'b1;
        return e;
    endfunction

    task automatic set_sizes(input int a0, a1, a2, a3, a4, a5, a6, a7);
        sz[0] = a0; sz[1] = a1; sz[2] = a2; sz[3] = a3;
        sz[4] = a4; sz[5] = a5; sz[6] = a6; sz[7] = a7;
        cfg_size_i = pack_cfg();
    endtask

    task automatic check_status(input string tag);
        logic [NUM_BKT-1:0] e_emp, e_full;
        logic [NUM_BKT*SZ_W-1:0] e_cnt;
        for (int i = 0; i < NUM_BKT; i++) begin
            e_emp[i]  = (ct[i] == 0);
            e_full[i] = (ct[i] == sz[i]);
            e_cnt[i*SZ_W +: SZ_W] = SZ_W'(ct[i]);
        end
        chk(count_o == e_cnt, tag, "count", count_o, e_cnt);
        chk(empty_o == e_emp, tag, "empty", empty_o, e_emp);
        chk(full_o == e_full, tag, "full", full_o, e_full);
        chk(ovf_o == m_ovf, tag, "overflow", ovf_o, m_ovf);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        enq_valid_i = 1'b0;
        deq_valid_i = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < NUM_BKT; i++) begin hd[i] = 0; ct[i] = 0; end
        m_ovf = '0;
    endtask

    task automatic step(input logic ev, input int eb, input logic dv, input int db,
                        input string tag);
        logic e_ok, d_ok;
        logic [MW-1:0] e_msg, d_msg;
        @(negedge clk);
        seq++;
        e_msg = {SRC_W'($urandom), DATA_W'(seq * 32'h9E37_79B1)};
        enq_valid_i = ev;
        enq_bkt_i   = eb[BKT_W-1:0];
        enq_src_i   = e_msg[MW-1:DATA_W];
        enq_data_i  = e_msg[DATA_W-1:0];
        deq_valid_i = dv;
        deq_bkt_i   = db[BKT_W-1:0];
        e_ok = ev && (ct[eb] < sz[eb]);
        d_ok = dv && (ct[db] > 0);
        d_msg = '0;
        if (ev && !e_ok) m_ovf[eb] = 1'b1;
        if (e_ok) q[eb][(hd[eb] + ct[eb]) % sz[eb]] = e_msg;
        if (d_ok) begin
            d_msg  = q[db][hd[db]];
            hd[db] = (hd[db] + 1) % sz[db];
        end
        if (e_ok) ct[eb]++;
        if (d_ok) ct[db]--;
        @(posedge clk);
        #1;
        enq_valid_i = 1'b0;
        deq_valid_i = 1'b0;
        chk(rd_valid_o == d_ok, tag, "rd_valid", rd_valid_o, d_ok);
        chk(crd_valid_o == d_ok, "R4", "crd_valid", crd_valid_o, d_ok);
        if (d_ok) begin
            chk(rd_data_o == d_msg[DATA_W-1:0], tag, "rd_data", rd_data_o, d_msg[DATA_W-1:0]);
            chk(rd_src_o == d_msg[MW-1:DATA_W], "R3", "rd_src", rd_src_o, d_msg[MW-1:DATA_W]);
            chk(crd_src_o == d_msg[MW-1:DATA_W], "R4", "crd_src", crd_src_o, d_msg[MW-1:DATA_W]);
            chk(crd_bkt_o == BKT_W'(db), "R4", "crd_bkt", crd_bkt_o, db);
        end
        check_status("R8");
    endtask

    initial begin
        #(5.0 * 200000);
        n_err++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        set_sizes(4, 4, 8, 16, 0, 32, 0, 64);
        do_reset();
        // R11: reset state
        chk(empty_o == '1 && count_o == '0, "R11", "empty/count", {empty_o, count_o}, {8'hFF, 72'h0});
        chk(ovf_o == '0 && !rd_valid_o && !crd_valid_o, "R11", "ovf/valid",
            {ovf_o, rd_valid_o, crd_valid_o}, '0);
        chk(cfg_err_o == 1'b0, "R2", "cfg_err default", cfg_err_o, 0);

        // R1 ordering with interleaved neighbour traffic
        for (int i = 0; i < 4; i++) begin
            step(1, 0, 0, 0, "R1");
            step(1, 1, 0, 0, "R1");
        end
        step(1, 0, 0, 0, "R6");          // bucket 0 full: dropped, overflow set
        step(0, 0, 0, 0, "R6");
        for (int i = 0; i < 4; i++) step(0, 0, 1, 0, "R1");
        // R10 wrap: refill after full drain
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, "R10");
        for (int i = 0; i < 3; i++) step(0, 0, 1, 0, "R10");
        for (int i = 0; i < 4; i++) step(0, 0, 1, 1, "R1");
        // R5 empty dequeue
        step(0, 0, 1, 3, "R5");
        step(0, 0, 1, 0, "R5");
        // R7 zero-sized bucket
        step(1, 4, 0, 0, "R7");
        step(0, 0, 1, 4, "R7");
        step(1, 6, 1, 6, "R7");
        // R9 simultaneous enqueue/dequeue
        step(1, 2, 0, 0, "R9");
        step(1, 2, 0, 0, "R9");
        for (int i = 0; i < 5; i++) step(1, 2, 1, 2, "R9");
        for (int i = 0; i < 6; i++) step(1, 2, 0, 0, "R9");
        step(1, 2, 1, 2, "R9");           // full: dequeue proceeds, enqueue dropped
        for (int i = 0; i < 7; i++) step(0, 0, 1, 2, "R9");

        // constrained random traffic
        for (int i = 0; i < 4000; i++) begin
            int eb = int'($urandom_range(NUM_BKT - 1));
            int db = int'($urandom_range(NUM_BKT - 1));
            logic ev = ($urandom_range(99) < 60);
            logic dv = ($urandom_range(99) < 55);
            step(ev, eb, dv, db, "R3");
        end

        // R2 layout checks, held in reset
        rst = 1'b1;
        begin
            int tbl [8][8] = '{
                '{4, 4, 8, 16, 0, 32, 0, 64},
                '{32, 64, 0, 0, 0, 0, 0, 0},
                '{24, 0, 0, 0, 0, 0, 0, 0},
                '{128, 128, 128, 0, 0, 0, 0, 0},
                '{32, 32, 64, 128, 0, 0, 0, 0},
                '{256, 0, 0, 0, 0, 0, 0, 0},
                '{16, 32, 0, 0, 0, 0, 0, 0},
                '{0, 0, 0, 0, 0, 0, 0, 256}};
            for (int k = 0; k < 8; k++) begin
                logic e;
                set_sizes(tbl[k][0], tbl[k][1], tbl[k][2], tbl[k][3],
                          tbl[k][4], tbl[k][5], tbl[k][6], tbl[k][7]);
                #2;
                e = exp_cfg_err();
                chk(cfg_err_o == e, "R2", "cfg_err", cfg_err_o, e);
            end
        end

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule